// File: doc/BRIEF.md
# Transceiver configuration latch bank

This block holds the configuration state of a two-lane serial transceiver: a receive lane with a reclocker, and a transmit lane. Software writes it through a narrow write port made of an address, a 4-bit data word and a write strobe. It reacts to an active-low asynchronous device reset. Its outputs are the decoded controls for the receive and transmit paths: receive enable, receive test/video mode, four serial output driver enables, transmit input clock source, PLL multiplier choice and transmit self-test disable.

The block also raises two flags when the stored settings are illegal. One covers an illegal receive mode code. The other covers a high multiplier rate paired with the low-speed range. Each lane gets a power-down output, which is asserted whenever both of that lane's drivers are off.

One latch, the phase-buffer re-centre latch, clears itself. Writing 0 to it requests a re-centre of the transmit phase-alignment buffer, and the latch returns to 1 on the next configuration clock. The request travels into the transmit input clock domain, where it appears as a single-cycle pulse.

Top module: `cfg_latch_bank`

## Requirements
- R1: After reset the outputs are: rx_en_o=0, rx_mode_o=2'b11, drv_en_o=4'b0000, tx_clk_sel_o=1, rate_sel_o=0, tx_bist_dis_o=1, recentre_o=0.
- R2: A write to address 0 stores data bit 0 into rx_en_o and data bits [2:1] into rx_mode_o. The new values are visible after the clk_i edge that samples the write.
- R3: rx_mode_o=2'b01 gives rx_video_o=1 and rx_bist_en_o=0. The code 2'b10 gives rx_bist_en_o=1 and rx_video_o=0. The codes 2'b00 and 2'b11 give rx_mode_bad_o=1 with both decode outputs at 0. rx_mode_bad_o is 0 for the two legal codes.
- R4: rate_bad_o is 1 exactly when rate_sel_o=1 and spd_hi_i=0. It follows spd_hi_i without a clock.
- R5: A write to address 1 stores data bits [3:0] into drv_en_o. Bit 0 is the receive primary driver, bit 1 the receive secondary, bit 2 the transmit primary and bit 3 the transmit secondary. Asserting rst_ni low forces drv_en_o to 0.
- R6: pwr_dn_o[0] is 1 exactly when drv_en_o[1:0]==0, and pwr_dn_o[1] is 1 exactly when drv_en_o[3:2]==0.
- R7: A write to address 2 stores data bit 0 into tx_clk_sel_o, bit 1 into rate_sel_o and bit 2 into tx_bist_dis_o. Transmit self-test is active when tx_bist_dis_o=0.
- R8: A write to address 3 with data bit 0 equal to 0 produces exactly one recentre_o pulse, one tx_clk_i cycle wide, within 10 tx_clk_i cycles. A write to address 3 with data bit 0 equal to 1 produces no pulse.
- R9: A write to any address from 4 upward changes no output. While wr_en_i is 0, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration write clock |
| tx_clk_i | input | 1 | Transmit input clock, the destination of the re-centre pulse |
| rst_ni | input | 1 | Active-low asynchronous device reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 4 | Write data |
| spd_hi_i | input | 1 | Speed range input; 0 selects the low range |
| rx_en_o | output | 1 | Receive lane enable |
| rx_mode_o | output | 2 | Raw receive mode code |
| rx_bist_en_o | output | 1 | Receive self-test active |
| rx_video_o | output | 1 | Receive video-data mode active |
| rx_mode_bad_o | output | 1 | Receive mode code is illegal |
| drv_en_o | output | 4 | Serial driver enables |
| pwr_dn_o | output | 2 | Per-lane logic power-down |
| tx_clk_sel_o | output | 1 | 1: reference clock captures transmit data; 0: transmit input clock does |
| rate_sel_o | output | 1 | 1: twenty-times multiplier; 0: ten-times |
| rate_bad_o | output | 1 | Reserved rate/speed combination |
| tx_bist_dis_o | output | 1 | Transmit self-test disabled when 1 |
| recentre_o | output | 1 | Phase-buffer re-centre pulse, tx_clk_i domain |

## Verification
All four receive mode codes are applied, so the two legal decodes can be told apart from each other and from both illegal codes, including the reset code 11. The driver enable word is tried with every lane pattern, which separates per-lane power-down from a global one. Writes to unused addresses and cycles with the strobe low tell ignored traffic apart from real updates. Re-centre writes with data bit 0 set to 0 and to 1, spread over a random run on unrelated clocks, show one pulse per request and none for the no-op value.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int DATA_W = 4;
  localparam int N_LANE = 2;
  localparam int N_DRV  = 2 * N_LANE;

  localparam int ADR_RX  = 0;
  localparam int ADR_DRV = 1;
  localparam int ADR_TX  = 2;
  localparam int ADR_PAB = 3;
  localparam int ADR_TOP = 3;

  localparam logic [1:0] MODE_VIDEO = 2'b01;
  localparam logic [1:0] MODE_BIST  = 2'b10;

  typedef struct packed {
    logic             rx_en;
    logic [1:0]       rx_mode;
    logic [N_DRV-1:0] drv_en;
    logic             clk_sel;
    logic             rate;
    logic             bist_dis;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    rx_en:    1'b0,
    rx_mode:  2'b11,
    drv_en:   '0,
    clk_sel:  1'b1,
    rate:     1'b0,
    bist_dis: 1'b1
  };
endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_bank_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output cfg_t              cfg_o,
  output logic              rc_tgl_o
);
  cfg_t cfg_q;
  logic pab_q;
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      pab_q <= 1'b1;
      tgl_q <= 1'b0;
    end else begin
      pab_q <= 1'b1;  // self-clearing
      if (!pab_q) tgl_q <= ~tgl_q;
      if (wr_en_i) begin
        if (wr_addr_i == ADDR_W'(ADR_RX)) begin
          cfg_q.rx_en   <= wr_data_i[0];
          cfg_q.rx_mode <= wr_data_i[2:1];
        end
        if (wr_addr_i == ADDR_W'(ADR_DRV)) cfg_q.drv_en <= wr_data_i[N_DRV-1:0];
        if (wr_addr_i == ADDR_W'(ADR_TX)) begin
          cfg_q.clk_sel  <= wr_data_i[0];
          cfg_q.rate     <= wr_data_i[1];
          cfg_q.bist_dis <= wr_data_i[2];
        end
        if (wr_addr_i == ADDR_W'(ADR_PAB)) pab_q <= wr_data_i[0];
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign rc_tgl_o = tgl_q;
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_bank_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic              spd_hi_i,
  output logic              bist_en_o,
  output logic              video_o,
  output logic              mode_bad_o,
  output logic              rate_bad_o,
  output logic [N_LANE-1:0] pwr_dn_o
);
  always_comb begin
    bist_en_o  = (cfg_i.rx_mode == MODE_BIST);
    video_o    = (cfg_i.rx_mode == MODE_VIDEO);
    mode_bad_o = !(bist_en_o || video_o);
    rate_bad_o = cfg_i.rate && !spd_hi_i;
  end

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    assign pwr_dn_o[g] = ~|cfg_i.drv_en[2*g +: 2];
  end
endmodule

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tgl_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_bank_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              tx_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [3:0]        wr_data_i,
  input  logic              spd_hi_i,
  output logic              rx_en_o,
  output logic [1:0]        rx_mode_o,
  output logic              rx_bist_en_o,
  output logic              rx_video_o,
  output logic              rx_mode_bad_o,
  output logic [3:0]        drv_en_o,
  output logic [1:0]        pwr_dn_o,
  output logic              tx_clk_sel_o,
  output logic              rate_sel_o,
  output logic              rate_bad_o,
  output logic              tx_bist_dis_o,
  output logic              recentre_o
);
  cfg_t cfg;
  logic rc_tgl;

  cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .rc_tgl_o  (rc_tgl)
  );

  cfg_decode u_dec (
    .cfg_i      (cfg),
    .spd_hi_i   (spd_hi_i),
    .bist_en_o  (rx_bist_en_o),
    .video_o    (rx_video_o),
    .mode_bad_o (rx_mode_bad_o),
    .rate_bad_o (rate_bad_o),
    .pwr_dn_o   (pwr_dn_o)
  );

  pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (tx_clk_i),
    .rst_ni  (rst_ni),
    .tgl_i   (rc_tgl),
    .pulse_o (recentre_o)
  );

  assign rx_en_o       = cfg.rx_en;
  assign rx_mode_o     = cfg.rx_mode;
  assign drv_en_o      = cfg.drv_en;
  assign tx_clk_sel_o  = cfg.clk_sel;
  assign rate_sel_o    = cfg.rate;
  assign tx_bist_dis_o = cfg.bist_dis;
endmodule

// File: rtl/cfg_latch_bank_chk.sv
module cfg_latch_bank_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              tx_clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              spd_hi_i,
  input logic              rx_en_o,
  input logic [1:0]        rx_mode_o,
  input logic              rx_bist_en_o,
  input logic              rx_video_o,
  input logic              rx_mode_bad_o,
  input logic [3:0]        drv_en_o,
  input logic [1:0]        pwr_dn_o,
  input logic              tx_clk_sel_o,
  input logic              rate_sel_o,
  input logic              rate_bad_o,
  input logic              tx_bist_dis_o,
  input logic              recentre_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_mode_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_bist_en_o && rx_video_o));

  p_mode_bad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_mode_bad_o == (rx_mode_o == 2'b00 || rx_mode_o == 2'b11));

  p_rate_bad_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_bad_o == (rate_sel_o && !spd_hi_i));

  p_lane_pwr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_dn_o[0] == (drv_en_o[1:0] == 2'b00)) && (pwr_dn_o[1] == (drv_en_o[3:2] == 2'b00)));

  p_pulse_width_r8: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    recentre_o |=> !recentre_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!wr_en_i || (wr_addr_i > ADDR_W'(3))) |->
      $stable(drv_en_o) && $stable(rx_mode_o) && $stable(rx_en_o) &&
      $stable(tx_clk_sel_o) && $stable(rate_sel_o) && $stable(tx_bist_dis_o));
endmodule

bind cfg_latch_bank cfg_latch_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .tx_clk_i      (tx_clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .spd_hi_i      (spd_hi_i),
  .rx_en_o       (rx_en_o),
  .rx_mode_o     (rx_mode_o),
  .rx_bist_en_o  (rx_bist_en_o),
  .rx_video_o    (rx_video_o),
  .rx_mode_bad_o (rx_mode_bad_o),
  .drv_en_o      (drv_en_o),
  .pwr_dn_o      (pwr_dn_o),
  .tx_clk_sel_o  (tx_clk_sel_o),
  .rate_sel_o    (rate_sel_o),
  .rate_bad_o    (rate_bad_o),
  .tx_bist_dis_o (tx_bist_dis_o),
  .recentre_o    (recentre_o)
);

// File: tb/cfg_latch_bank_bench.sv
module cfg_latch_bank_bench;
  localparam int AW = 3;

  logic clk = 1'b0, tx_clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, spd = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0] wdat = '0;
  logic rx_en, bist_en, video, mode_bad, clk_sel, rate, rate_bad, bist_dis, rc;
  logic [1:0] mode, pwr;
  logic [3:0] drv;

  int n_chk = 0, n_fail = 0;
  int exp_pulses = 0, got_pulses = 0, last_rc = -100, cyc = 0;

  logic       m_rx_en, m_clk_sel, m_rate, m_bist;
  logic [1:0] m_mode;
  logic [3:0] m_drv;

  always #4 clk = ~clk;      // 125 MHz
  always #7 tx_clk = ~tx_clk;

  always @(negedge tx_clk) if (rst_n && rc) got_pulses++;

  cfg_latch_bank #(.ADDR_W(AW)) u_cfg_latch_bank (
    .clk_i(clk), .tx_clk_i(tx_clk), .rst_ni(rst_n),
    .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(wdat), .spd_hi_i(spd),
    .rx_en_o(rx_en), .rx_mode_o(mode), .rx_bist_en_o(bist_en), .rx_video_o(video),
    .rx_mode_bad_o(mode_bad), .drv_en_o(drv), .pwr_dn_o(pwr),
    .tx_clk_sel_o(clk_sel), .rate_sel_o(rate), .rate_bad_o(rate_bad),
    .tx_bist_dis_o(bist_dis), .recentre_o(rc)
  );

  function automatic logic f_bad(logic [1:0] m);
    return (m == 2'b00) || (m == 2'b11);
  endfunction

  function automatic logic [1:0] f_pwr(logic [3:0] d);
    return {d[3:2] == 2'b00, d[1:0] == 2'b00};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rx_en = 0; m_mode = 2'b11; m_drv = 0; m_clk_sel = 1; m_rate = 0; m_bist = 1;
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 rx_en"}, rx_en, m_rx_en);
    chk({tag, " R2 rx_mode"}, mode, m_mode);
    chk({tag, " R3 video"}, video, m_mode == 2'b01);
    chk({tag, " R3 bist"}, bist_en, m_mode == 2'b10);
    chk({tag, " R3 bad"}, mode_bad, f_bad(m_mode));
    chk({tag, " R5 drv"}, drv, m_drv);
    chk({tag, " R6 pwr"}, pwr, f_pwr(m_drv));
    chk({tag, " R7 clk_sel"}, clk_sel, m_clk_sel);
    chk({tag, " R7 rate"}, rate, m_rate);
    chk({tag, " R7 bist_dis"}, bist_dis, m_bist);
    chk({tag, " R4 rate_bad"}, rate_bad, m_rate && !spd);
  endtask

  // drive at negedge, model the write, check at next negedge
  task automatic cyc_wr(logic w, logic [AW-1:0] a, logic [3:0] d, logic s, string tag);
    we = w; addr = a; wdat = d; spd = s;
    if (w) begin
      case (int'(a))
        0: begin m_rx_en = d[0]; m_mode = d[2:1]; end
        1: m_drv = d;
        2: begin m_clk_sel = d[0]; m_rate = d[1]; m_bist = d[2]; end
        3: if (!d[0]) begin exp_pulses++; last_rc = cyc; end
        default: ;
      endcase
    end
    @(negedge clk);
    cyc++;
    we = 0;
    check_all(tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (4) @(negedge clk);
    check_all("R1 reset");
    chk("R1 recentre idle", rc, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 every mode code
    cyc_wr(1, 0, 4'b0011, 1, "R3 mode01");
    cyc_wr(1, 0, 4'b0100, 1, "R3 mode10");
    cyc_wr(1, 0, 4'b0001, 1, "R3 mode00");
    cyc_wr(1, 0, 4'b0111, 1, "R3 mode11");
    // R4 rate/speed
    cyc_wr(1, 2, 4'b0010, 0, "R4 rate1 spd0");
    cyc_wr(0, 2, 4'b0000, 1, "R4 rate1 spd1");
    cyc_wr(1, 2, 4'b0101, 0, "R7 rate0 bist");
    // R6 every driver pattern
    for (int i = 0; i < 16; i++) cyc_wr(1, 1, 4'(i), 1, "R6 drv sweep");
    // R9 unused addresses and strobe low
    for (int a = 4; a < 8; a++) cyc_wr(1, AW'(a), 4'hA, 1, "R9 unused");
    cyc_wr(0, 1, 4'h0, 1, "R9 strobe low");
    cyc_wr(0, 0, 4'h2, 1, "R9 strobe low");

    // R8 directed
    got_pulses = 0; exp_pulses = 0;
    cyc_wr(1, 3, 4'h0, 1, "R8 write 0");
    repeat (10) @(negedge tx_clk);
    chk("R8 one pulse", got_pulses, 1);
    cyc_wr(1, 3, 4'h1, 1, "R8 write 1");
    repeat (10) @(negedge tx_clk);
    chk("R8 no pulse for 1", got_pulses, 1);

    // random run
    got_pulses = 0; exp_pulses = 0;
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic [3:0]    d;
      logic          w;
      a = AW'($urandom % 8);
      d = 4'($urandom);
      w = ($urandom % 4) != 0;
      if (w && a == 3 && !d[0] && (cyc - last_rc) < 8) d[0] = 1'b1;
      cyc_wr(w, a, d, 1'($urandom), "rand");
    end
    repeat (10) @(negedge tx_clk);
    chk("R8 random pulse count", got_pulses, exp_pulses);

    // R5 reset clears drivers
    cyc_wr(1, 1, 4'hF, 1, "R5 drv on");
    rst_n = 1'b0;
    #1;
    model_reset();
    check_all("R5 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 recentre after reset", rc, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule